// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register Block

This block holds the control state for one bank of general-purpose pins: four ports of eight pins, 32 pins in total. A processor reaches it over a small memory-mapped read/write bus. Each port has a mode register that puts its pins in GPIO mode, a drive-enable register, an output-value register and a read-only input register. The block drives the pin output value and output-enable lines and samples the pin inputs through a two-flop synchroniser.

Every register also appears in an alias window 0x80 bytes above the plain one. A write there carries a per-bit mask in data bits 15:8, so software can change one pin atomically without a read-modify-write.

A two-state bus sequencer handles each access. In `BUS_IDLE`, `bus_ready` is high and a request (`bus_wr` or `bus_rd`) is accepted on the clock edge. That edge moves the sequencer to `BUS_RESP`, where `bus_ack` is high for one cycle with the read data. The next edge returns it to `BUS_IDLE` unconditionally. No other transitions exist.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all mode, drive-enable and output-value bits are 0, `pin_oe` and `pin_out` are all 0, and `bus_ready` is 1.
- R2: Address decode: byte address bits 3:2 pick the port and bits 5:4 pick the register (0 mode, 1 drive-enable, 2 output value, 3 input). A plain write (bit 7 clear) loads `bus_wdata[7:0]` into the selected register of the selected port only.
- R3: An alias write (address bit 7 set) loads bit n of the selected register from `bus_wdata[n]` only where `bus_wdata[8+n]` is 1. The other bits keep their value. A mask of zero changes nothing.
- R4: Writes to the input register, plain or alias, have no effect.
- R5: Pin 8p+n has `pin_out` equal to output-value bit n of port p. Its `pin_oe` is high only when both its mode bit and its drive-enable bit are 1.
- R6: A value on `pin_in` sampled at clock edge k is in the input register after edge k+1. A read accepted at edge k+1 still returns the older value, and a read accepted at edge k+2 or later returns the new one.
- R7: A read, at a plain or alias address, returns the register in `bus_rdata[7:0]` and zero in bits 31:8, during the `bus_ack` cycle.
- R8: A request is accepted only while `bus_ready` is 1. `bus_ack` is high for exactly the cycle after acceptance, and `bus_ready` is low in that cycle. A request held during the ack cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 8 | Byte address within the bank |
| bus_wdata | input | 32 | Write data; bits 15:8 are the mask for alias writes |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ready | output | 1 | Sequencer idle, request may be issued |
| bus_ack | output | 1 | Access completed |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |

## Verification
The input synchroniser can advance the input register on the same edge that accepts a read of that register. The bench provokes this by changing `pin_in` and then issuing a read that is accepted exactly on the second edge. That read must return the old byte, and a read on the following access must return the new one. A second collision, a write request still held during the ack cycle, is provoked by changing the data in that cycle. It is judged by reading the register back and checking that the first value is the one kept.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
    typedef enum logic [1:0] {
        REG_MODE  = 2'd0,
        REG_DRIVE = 2'd1,
        REG_VALUE = 2'd2,
        REG_INPUT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic              masked,
    input  logic [2*PINS-1:0] wdata,
    output logic [PINS-1:0]   mode_q,
    output logic [PINS-1:0]   drive_q,
    output logic [PINS-1:0]   value_q
);
    logic [PINS-1:0] bit_mask;
    logic [PINS-1:0] target;
    logic [PINS-1:0] merged;

    assign bit_mask = masked ? wdata[2*PINS-1:PINS] : {PINS{1'b1}};

    always_comb begin
        unique case (sel)
            REG_MODE:  target = mode_q;
            REG_DRIVE: target = drive_q;
            REG_VALUE: target = value_q;
            default:   target = '0;
        endcase
    end

    assign merged = (target & ~bit_mask) | (wdata[PINS-1:0] & bit_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            drive_q <= '0;
            value_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                REG_MODE:  mode_q  <= merged;
                REG_DRIVE: drive_q <= merged;
                REG_VALUE: value_q <= merged;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bus_fsm.sv
`timescale 1ns/1ps
module gpio_bus_fsm
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic ready,
    output logic ack
);
    bus_state_e state_q;
    bus_state_e state_d;

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready  = 1'b0;
        ack    = 1'b0;
        accept = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                ready  = 1'b1;
                accept = req;
            end
            BUS_RESP: ack = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PORTS     = 4,
    parameter int PINS      = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int ALIAS_OFS = 'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_ready,
    output logic                  bus_ack,
    input  logic [PORTS*PINS-1:0] pin_in,
    output logic [PORTS*PINS-1:0] pin_out,
    output logic [PORTS*PINS-1:0] pin_oe
);
    localparam int NPINS     = PORTS * PINS;
    localparam int PORT_W    = (PORTS > 1) ? $clog2(PORTS) : 1;
    localparam int PORT_LSB  = 2;
    localparam int SEL_LSB   = 4;
    localparam int ALIAS_BIT = $clog2(ALIAS_OFS);

    logic              accept;
    logic [PORT_W-1:0] port_idx;
    reg_sel_e          sel;
    logic              masked;
    logic [NPINS-1:0]  mode_flat;
    logic [NPINS-1:0]  drive_flat;
    logic [NPINS-1:0]  value_flat;
    logic [NPINS-1:0]  input_flat;
    logic [PINS-1:0]   rd_byte;

    assign port_idx = bus_addr[PORT_LSB +: PORT_W];
    assign sel      = reg_sel_e'(bus_addr[SEL_LSB +: 2]);
    assign masked   = bus_addr[ALIAS_BIT];

    gpio_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_wr | bus_rd),
        .accept (accept),
        .ready  (bus_ready),
        .ack    (bus_ack)
    );

    gpio_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (input_flat)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic wr_en;
        assign wr_en = accept && bus_wr && (port_idx == PORT_W'(p)) && (sel != REG_INPUT);

        gpio_port_regs #(.PINS(PINS)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .sel     (sel),
            .masked  (masked),
            .wdata   (bus_wdata[2*PINS-1:0]),
            .mode_q  (mode_flat[p*PINS +: PINS]),
            .drive_q (drive_flat[p*PINS +: PINS]),
            .value_q (value_flat[p*PINS +: PINS])
        );
    end

    assign pin_out = value_flat;
    assign pin_oe  = mode_flat & drive_flat;

    always_comb begin
        rd_byte = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (port_idx == PORT_W'(p)) begin
                unique case (sel)
                    REG_MODE:  rd_byte = mode_flat[p*PINS +: PINS];
                    REG_DRIVE: rd_byte = drive_flat[p*PINS +: PINS];
                    REG_VALUE: rd_byte = value_flat[p*PINS +: PINS];
                    REG_INPUT: rd_byte = input_flat[p*PINS +: PINS];
                    default:   rd_byte = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (accept) begin
            bus_rdata <= (bus_rd && !bus_wr) ? DATA_W'(rd_byte) : '0;
        end
    end
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
    parameter int NPINS     = 32,
    parameter int PINS      = 8,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int ALIAS_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready,
    input logic              bus_ack,
    input logic              accept,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  mode_flat,
    input logic [NPINS-1:0]  drive_flat,
    input logic [NPINS-1:0]  value_flat,
    input logic [NPINS-1:0]  input_flat
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    assert_ack_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bus_ack);

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_busy_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> !bus_ready);

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[DATA_W-1:PINS] == '0));

    assert_empty_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_wr && bus_addr[ALIAS_BIT] && (bus_wdata[2*PINS-1:PINS] == '0))
        |=> ($stable(mode_flat) && $stable(drive_flat) && $stable(value_flat)));

    assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2) |-> (input_flat == $past(pin_in, 2)));
endmodule

bind gpio_bank gpio_bank_chk #(
    .NPINS     (NPINS),
    .PINS      (PINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ALIAS_BIT (ALIAS_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .bus_ack    (bus_ack),
    .accept     (accept),
    .pin_in     (pin_in),
    .mode_flat  (mode_flat),
    .drive_flat (drive_flat),
    .value_flat (value_flat),
    .input_flat (input_flat)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        bus_ack;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_bank i_gpio_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_ack   (bus_ack),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    function automatic logic [7:0] adr(input bit alias_w, input int sel, input int port);
        return (alias_w ? 8'h80 : 8'h00) | 8'(sel << 4) | 8'(port << 2);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 bus_ready", {31'h0, bus_ready}, 32'h1);
        bus_read(adr(0, 0, 2), d);
        check("R1 mode port2", d, 32'h0);
    endtask

    task automatic t_plain_write();
        logic [31:0] d;
        bus_write(adr(0, 2, 1), 32'hFFFF_00A5);
        bus_read(adr(0, 2, 1), d);
        check("R2 value port1 readback", d, 32'h0000_00A5);
        check("R5 pin_out port1", pin_out, 32'h0000_A500);
        bus_read(adr(0, 2, 0), d);
        check("R2 value port0 untouched", d, 32'h0);
    endtask

    task automatic t_oe_gate();
        bus_write(adr(0, 1, 1), 32'h0000_00FF);
        check("R5 oe without mode", pin_oe, 32'h0);
        bus_write(adr(0, 0, 1), 32'h0000_000F);
        check("R5 oe with mode", pin_oe, 32'h0000_0F00);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        bus_write(adr(1, 2, 1), 32'h0000_1010);
        check("R3 alias set bit4", pin_out, 32'h0000_B500);
        bus_write(adr(1, 2, 1), 32'h0000_0100);
        check("R3 alias clear bit0", pin_out, 32'h0000_B400);
        bus_write(adr(1, 2, 1), 32'h0000_00FF);
        check("R3 alias empty mask", pin_out, 32'h0000_B400);
        bus_read(adr(1, 2, 1), d);
        check("R7 alias read", d, 32'h0000_00B4);
    endtask

    task automatic t_input_ignore();
        logic [31:0] d;
        pin_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        bus_write(adr(0, 3, 0), 32'hFFFF_FFFF);
        bus_write(adr(1, 3, 0), 32'h0000_FF00);
        bus_read(adr(0, 3, 0), d);
        check("R4 input write ignored", d, 32'h0000_0078);
        bus_read(adr(1, 3, 2), d);
        check("R7 alias input read", d, 32'h0000_0034);
    endtask

    task automatic t_sync_collision();
        logic [31:0] d;
        @(negedge clk);
        pin_in = 32'h8734_5678;
        bus_read(adr(0, 3, 3), d);
        check("R6 read on update edge old", d, 32'h0000_0012);
        bus_read(adr(0, 3, 3), d);
        check("R6 read after update new", d, 32'h0000_0087);
    endtask

    task automatic t_handshake();
        logic [31:0] d;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = adr(0, 2, 2); bus_wdata = 32'h0000_003C;
        @(negedge clk);
        check("R8 ack after accept", {31'h0, bus_ack}, 32'h1);
        check("R8 not ready in ack", {31'h0, bus_ready}, 32'h0);
        bus_wdata = 32'h0000_00C3;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 single ack", {31'h0, bus_ack}, 32'h0);
        bus_read(adr(0, 2, 2), d);
        check("R8 held request ignored", d, 32'h0000_003C);
        check("R5 pin_out port2", pin_out[23:16], 32'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_write();
        t_oe_gate();
        t_alias();
        t_input_ignore();
        t_sync_collision();
        t_handshake();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule